// File: doc/BRIEF.md
# Two-Bus Word Memory Controller with Byte Parity

This block fronts a single word-wide storage array that is reached from two separate request buses, called port A and port B. Each port presents a word address, a read or a write strobe, 16 bits of write data and two write parity bits, and receives read data, two generated parity bits, a one-cycle ready pulse and a per-byte parity error indication. Only one access owns the array at a time, and each access occupies it for a parameterised number of clocks to stand in for the fixed cycle time of the storage.

When both ports ask in the same idle cycle, port A is served first and port B keeps its request up until its own ready arrives. An access that has started is never pre-empted: a port A request that shows up while port B owns the array waits for that access to end. Parity is odd and kept per byte, so each half of the word is checked and stored on its own; a byte whose parity is wrong on a write is reported and left unchanged in the array while the other byte is still written.

Top module: `dpmem_ctrl`

## Requirements
- R1: After reset, both ready outputs and both parity error outputs are low and the controller is idle.
- R2: A read returns the word last written to that address by either port; the read parity outputs are odd per byte, bit 1 covering data bits 15:8 and bit 0 covering bits 7:0 (byte plus its bit holds an odd number of ones).
- R3: A request presented while the controller is idle and unopposed gets its ready exactly BUSY_CYC+1 rising edges after it is first driven, and ready stays high for exactly one cycle.
- R4: When both ports request in the same idle cycle, port A completes before port B, and port B is still served afterwards without dropping its request.
- R5: A port A request that arrives while a port B access is in progress waits; port B completes first.
- R6: On a write, a parity error pulse is raised together with that port's ready, and the two-bit mask shows which byte failed (bit 1 upper, bit 0 lower); a write with correct parity raises no error.
- R7: A byte whose write parity is wrong is not stored; the other byte of the same word is stored normally.
- R8: Reads never raise the parity error output.
- R9: The two ready outputs are never high in the same cycle, and a parity error is never raised without the matching ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_rd | input | 1 | Port A read request, held until ready |
| a_wr | input | 1 | Port A write request, held until ready |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_wpar | input | 2 | Port A write parity, bit 1 upper byte, bit 0 lower byte |
| a_rdata | output | 16 | Port A read data, valid with ready on a read |
| a_rpar | output | 2 | Port A generated odd parity of a_rdata |
| a_ready | output | 1 | Port A access complete, one-cycle pulse |
| a_perr | output | 1 | Port A write parity error, with ready |
| a_perr_mask | output | 2 | Port A failing bytes, bit 1 upper, bit 0 lower |
| b_rd | input | 1 | Port B read request, held until ready |
| b_wr | input | 1 | Port B write request, held until ready |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_wpar | input | 2 | Port B write parity, bit 1 upper byte, bit 0 lower byte |
| b_rdata | output | 16 | Port B read data, valid with ready on a read |
| b_rpar | output | 2 | Port B generated odd parity of b_rdata |
| b_ready | output | 1 | Port B access complete, one-cycle pulse |
| b_perr | output | 1 | Port B write parity error, with ready |
| b_perr_mask | output | 2 | Port B failing bytes, bit 1 upper, bit 0 lower |

## Verification
The assertions rely on each requester keeping its strobe, address and data steady from the cycle it raises a request until the cycle in which its ready is seen, dropping it in that cycle, and never raising read and write together. The bench drives every request through one task that obeys exactly this: it sets the inputs on a falling edge, leaves them untouched until ready is sampled high, clears the strobes at that same falling edge and then idles one cycle. Contention cases are produced by starting two such tasks in parallel or staggered by two cycles, so the priority and wait properties see real overlap without any request being withdrawn early.

// File: rtl/dpmem_pkg.sv
package dpmem_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int PORTS   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic              wr;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  par;
    } op_t;

    // odd parity bit for one byte: byte plus bit has an odd count of ones
    function automatic logic odd_bit(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/dpmem_pargen.sv
module dpmem_pargen
    import dpmem_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    output logic [LANES-1:0]  par
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign par[l] = odd_bit(data[l*BYTE_W +: BYTE_W]);
        end
    endgenerate
endmodule

// File: rtl/dpmem_arb.sv
module dpmem_arb
    import dpmem_pkg::*;
(
    input  logic [PORTS-1:0] req,
    output logic [PORTS-1:0] gnt
);
    // lowest index wins: index 0 is port A
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < PORTS; i++) begin
            gnt[i] = req[i] & ~taken;
            taken  = taken | req[i];
        end
    end
endmodule

// File: rtl/dpmem_seq.sv
module dpmem_seq
    import dpmem_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       any_req,
    output logic       grant_en,
    output logic       fire,
    output seq_state_t state
);
    localparam int CNT_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);

    logic [CNT_W-1:0] cnt;

    assign grant_en = (state == ST_IDLE) && any_req;
    assign fire     = (state == ST_BUSY) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (any_req) begin
                    state <= ST_BUSY;
                    cnt   <= CNT_W'(BUSY_CYC - 1);
                end
                ST_BUSY: if (cnt == '0) state <= ST_DONE;
                         else           cnt   <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dpmem_ctrl.sv
module dpmem_ctrl
    import dpmem_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_rd,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [15:0]       a_wdata,
    input  logic [1:0]        a_wpar,
    output logic [15:0]       a_rdata,
    output logic [1:0]        a_rpar,
    output logic              a_ready,
    output logic              a_perr,
    output logic [1:0]        a_perr_mask,
    input  logic              b_rd,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [15:0]       b_wdata,
    input  logic [1:0]        b_wpar,
    output logic [15:0]       b_rdata,
    output logic [1:0]        b_rpar,
    output logic              b_ready,
    output logic              b_perr,
    output logic [1:0]        b_perr_mask
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [PORTS-1:0]  req, gnt;
    logic [ADDR_W-1:0] addr_in [PORTS];
    op_t               op_in   [PORTS];

    assign req        = {b_rd | b_wr, a_rd | a_wr};
    assign addr_in[0] = a_addr;
    assign addr_in[1] = b_addr;
    assign op_in[0]   = '{wr: a_wr, data: a_wdata, par: a_wpar};
    assign op_in[1]   = '{wr: b_wr, data: b_wdata, par: b_wpar};

    logic       grant_en, fire;
    seq_state_t state;

    dpmem_arb u_arb (.req(req), .gnt(gnt));

    dpmem_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk(clk), .rst(rst), .any_req(|req),
        .grant_en(grant_en), .fire(fire), .state(state)
    );

    // latched access owned by the sequencer
    logic              owner;
    logic [ADDR_W-1:0] op_addr;
    op_t               op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owner   <= 1'b0;
            op_addr <= '0;
            op_q    <= '0;
        end else if (grant_en) begin
            owner   <= gnt[1];
            op_addr <= addr_in[gnt[1]];
            op_q    <= op_in[gnt[1]];
        end
    end

    logic [LANES-1:0] wr_gen, wr_bad;
    dpmem_pargen u_wchk (.data(op_q.data), .par(wr_gen));
    assign wr_bad = wr_gen ^ op_q.par;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (fire && op_q.wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wr_bad[l])
                    mem[op_addr][l*BYTE_W +: BYTE_W] <= op_q.data[l*BYTE_W +: BYTE_W];
            end
        end
    end

    logic [WORD_W-1:0] rdata_q [PORTS];
    logic [LANES-1:0]  rpar_w  [PORTS];
    logic [PORTS-1:0]  ready_q;
    logic [LANES-1:0]  mask_q  [PORTS];

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            dpmem_pargen u_rgen (.data(rdata_q[p]), .par(rpar_w[p]));

            always_ff @(posedge clk) begin
                if (rst) begin
                    rdata_q[p] <= '0;
                    ready_q[p] <= 1'b0;
                    mask_q[p]  <= '0;
                end else if (fire && (owner == 1'(p))) begin
                    ready_q[p] <= 1'b1;
                    mask_q[p]  <= op_q.wr ? wr_bad : '0;
                    if (!op_q.wr) rdata_q[p] <= mem[op_addr];
                end else begin
                    ready_q[p] <= 1'b0;
                    mask_q[p]  <= '0;
                end
            end
        end
    endgenerate

    assign a_rdata     = rdata_q[0];
    assign a_rpar      = rpar_w[0];
    assign a_ready     = ready_q[0];
    assign a_perr_mask = mask_q[0];
    assign a_perr      = |mask_q[0];
    assign b_rdata     = rdata_q[1];
    assign b_rpar      = rpar_w[1];
    assign b_ready     = ready_q[1];
    assign b_perr_mask = mask_q[1];
    assign b_perr      = |mask_q[1];

    // inputs assumed: strobes held until ready, never read and write together
    a_r4_a_wins: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req[0] && req[1]) |=> (owner == 1'b0));
    a_r5_a_waits: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && owner == 1'b1 && req[0]) |=> !a_ready);
    a_r5_owner_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && $past(state == ST_BUSY)) |-> $stable(owner));
    a_r3_ready_pulse_a: assert property (@(posedge clk) disable iff (rst)
        a_ready |=> !a_ready);
    a_r3_ready_pulse_b: assert property (@(posedge clk) disable iff (rst)
        b_ready |=> !b_ready);
    a_r9_one_ready: assert property (@(posedge clk) disable iff (rst)
        !(a_ready && b_ready));
    a_r9_perr_with_ready: assert property (@(posedge clk) disable iff (rst)
        (a_perr |-> a_ready) and (b_perr |-> b_ready));
    a_r8_read_clean: assert property (@(posedge clk) disable iff (rst)
        (fire && !op_q.wr) |=> (!a_perr && !b_perr));
endmodule

// File: tb/dpmem_ctrl_bench.sv
module dpmem_ctrl_bench;
    localparam int AW = 6;
    localparam int BC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          rd [2], wr [2], rdy [2], pe [2];
    logic [AW-1:0] ad [2];
    logic [15:0]   wd [2], rdq [2];
    logic [1:0]    wp [2], rpq [2], pm [2];

    dpmem_ctrl #(.ADDR_W(AW), .BUSY_CYC(BC)) u_dpmem_ctrl (
        .clk(clk), .rst(rst),
        .a_rd(rd[0]), .a_wr(wr[0]), .a_addr(ad[0]), .a_wdata(wd[0]), .a_wpar(wp[0]),
        .a_rdata(rdq[0]), .a_rpar(rpq[0]), .a_ready(rdy[0]), .a_perr(pe[0]), .a_perr_mask(pm[0]),
        .b_rd(rd[1]), .b_wr(wr[1]), .b_addr(ad[1]), .b_wdata(wd[1]), .b_wpar(wp[1]),
        .b_rdata(rdq[1]), .b_rpar(rpq[1]), .b_ready(rdy[1]), .b_perr(pe[1]), .b_perr_mask(pm[1])
    );

    typedef struct {
        bit          is_rd;
        logic [15:0] data;
        logic [1:0]  mask;
        string       tag;
    } exp_t;

    exp_t        qa [$];
    exp_t        qb [$];
    logic [15:0] shadow [64];
    int          checks = 0, fails = 0, seq_ctr = 0;
    int          done_seq [2];
    bit          prev_rdy [2];

    function automatic logic [1:0] good_par(input logic [15:0] d);
        return {($countones(d[15:8]) % 2) == 0, ($countones(d[7:0]) % 2) == 0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // must be called at a falling edge; returns one idle cycle after ready
    task automatic op(input int p, input bit w, input logic [AW-1:0] a,
                      input logic [15:0] d, input logic [1:0] par,
                      input int lat, input string tag);
        exp_t e;
        int   n;
        e.is_rd = !w;
        e.tag   = tag;
        e.data  = '0;
        e.mask  = '0;
        if (w) begin
            e.mask = par ^ good_par(d);
            if (!e.mask[1]) shadow[a][15:8] = d[15:8];
            if (!e.mask[0]) shadow[a][7:0]  = d[7:0];
        end else begin
            e.data = shadow[a];
        end
        if (p == 0) qa.push_back(e); else qb.push_back(e);
        rd[p] = !w; wr[p] = w; ad[p] = a; wd[p] = d; wp[p] = par;
        n = 0;
        do begin @(negedge clk); n++; end while (!rdy[p]);
        seq_ctr++;
        done_seq[p] = seq_ctr;
        rd[p] = 1'b0; wr[p] = 1'b0;
        if (lat > 0) check({tag, " latency"}, n, lat);
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rdy[0] && rdy[1]) check("R9 both ready", 1, 0);
            for (int p = 0; p < 2; p++) begin
                if (rdy[p]) begin
                    exp_t e;
                    if (prev_rdy[p]) check("R3 ready wider than one cycle", 1, 0);
                    if ((p == 0 ? qa.size() : qb.size()) == 0) begin
                        check("R3 unexpected ready", 1, 0);
                    end else begin
                        e = (p == 0) ? qa.pop_front() : qb.pop_front();
                        if (e.is_rd) begin
                            check({e.tag, " R2 rdata"}, rdq[p], e.data);
                            check({e.tag, " R2 rpar"}, rpq[p], good_par(e.data));
                            check({e.tag, " R8 read perr"}, pe[p], 0);
                        end else begin
                            check({e.tag, " R6 mask"}, pm[p], e.mask);
                            check({e.tag, " R6 perr"}, pe[p], e.mask != 0);
                        end
                    end
                end else if (pe[p]) begin
                    check("R9 perr without ready", 1, 0);
                end
                prev_rdy[p] = rdy[p];
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            rd[p] = 0; wr[p] = 0; ad[p] = '0; wd[p] = '0; wp[p] = '0;
            prev_rdy[p] = 0; done_seq[p] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 a_ready", rdy[0], 0);
        check("R1 b_ready", rdy[1], 0);
        check("R1 a_perr", pe[0], 0);
        check("R1 b_perr", pe[1], 0);

        // R3 latency and R2 cross-port data, boundary addresses and patterns
        op(0, 1, 6'd5,  16'hA55A, good_par(16'hA55A), BC+1, "R3 wrA");
        op(1, 1, 6'd9,  16'h0F01, good_par(16'h0F01), BC+1, "R3 wrB");
        op(0, 1, 6'd0,  16'h0000, good_par(16'h0000), BC+1, "R2 wr zero");
        op(1, 1, 6'd63, 16'hFFFF, good_par(16'hFFFF), BC+1, "R2 wr ones");
        op(0, 0, 6'd9,  16'h0, 2'b00, BC+1, "R2 rdA");
        op(1, 0, 6'd5,  16'h0, 2'b00, BC+1, "R2 rdB");
        op(0, 0, 6'd63, 16'h0, 2'b00, 0, "R2 rd ones");
        op(1, 0, 6'd0,  16'h0, 2'b00, 0, "R2 rd zero");

        // R6 R7 per-byte parity faults
        op(0, 1, 6'd5, 16'h1234, good_par(16'h1234) ^ 2'b10, 0, "R7 upper bad");
        op(0, 0, 6'd5, 16'h0, 2'b00, 0, "R7 rd after upper bad");
        op(1, 1, 6'd9, 16'h7788, good_par(16'h7788) ^ 2'b01, 0, "R7 lower bad");
        op(1, 0, 6'd9, 16'h0, 2'b00, 0, "R7 rd after lower bad");
        op(0, 1, 6'd0, 16'hBEEF, good_par(16'hBEEF) ^ 2'b11, 0, "R7 both bad");
        op(1, 0, 6'd0, 16'h0, 2'b00, 0, "R7 rd after both bad");

        // R4 simultaneous requests
        fork
            op(0, 1, 6'd20, 16'h1111, good_par(16'h1111), 0, "R4 A");
            op(1, 1, 6'd21, 16'h2222, good_par(16'h2222), 0, "R4 B");
        join
        check("R4 A before B", done_seq[0] < done_seq[1], 1);
        op(0, 0, 6'd21, 16'h0, 2'b00, 0, "R4 rd B data");
        op(1, 0, 6'd20, 16'h0, 2'b00, 0, "R4 rd A data");

        // R5 port A arrives during a port B access
        fork
            op(1, 0, 6'd20, 16'h0, 2'b00, 0, "R5 B first");
            begin
                repeat (2) @(negedge clk);
                op(0, 0, 6'd21, 16'h0, 2'b00, 0, "R5 A waits");
            end
        join
        check("R5 B before A", done_seq[1] < done_seq[0], 1);

        repeat (3) @(negedge clk);
        check("R3 all expected completions seen", qa.size() + qb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule